// File: doc/BRIEF.md
# Saturating DSP Arithmetic Unit

This unit performs the clamping integer operations used in fixed-point signal processing on 32-bit operands. An opcode selects one of ten operations: signed and unsigned add and subtract with saturation, a doubling step with saturation, signed or unsigned clipping to a selectable bit position (on the whole word or on two independent 16-bit lanes), and a plain wrapping add that still reports signed overflow. The result and a per-operation clamp indication are formed combinationally from the inputs.

Each accepted operation that clamps sets a sticky overflow flag. Arithmetic never lowers the flag, so software can run a long stretch of operations and test afterwards whether any of them lost precision. The flag drops only on reset or when the dedicated clear input is pulsed.

Operations travel on a valid/ready pair. Because the unit has no storage in the data path, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. An operation counts as accepted in a cycle where `in_valid` and `out_ready` are both high. While the consumer holds `out_ready` low, the producer must keep its operands stable. The result stays visible during a stall, but the flag is not updated.

Top module: `sat_alu`

## Requirements
- R1: Opcode 1 (signed saturating add) returns a+b. When both operands have the same sign and the sum's sign differs from a, it returns 0x7FFFFFFF for non-negative a and 0x80000000 for negative a, and it raises res_clamp.
- R2: Opcode 2 (signed saturating subtract) returns a-b. When the operand signs differ and the difference's sign differs from a, it clamps to the same two values as R1 and raises res_clamp.
- R3: Opcode 3 (doubling saturate) takes a as signed. It returns 0x7FFFFFFF for a >= 0x40000000 and 0x80000000 for a <= 0xC0000000, raising res_clamp in both cases. Otherwise it returns a shifted left by one.
- R4: Opcode 4 (unsigned add) returns all ones and raises res_clamp on carry out. Opcode 5 (unsigned subtract) returns 0 and raises res_clamp on borrow.
- R5: Opcode 6 (signed clip) works with m = 2^sat_pos - 1. Let t be a shifted right arithmetically by sat_pos. If t > 0 the result is m. If t < -1 the result is ~m. Both of these raise res_clamp. Otherwise a passes through unchanged.
- R6: Opcode 7 (unsigned clip) returns 0 for negative a and 2^sat_pos - 1 for a above that limit, raising res_clamp in both cases. Otherwise a passes through.
- R7: Opcodes 8 and 9 apply R5 and R6 respectively to each sign-extended 16-bit half of a independently. Lane 0 is bits 15:0 and lane 1 is bits 31:16, and each lane result goes back into its own half. A clamp in either lane raises res_clamp.
- R8: Opcode 0 (wrapping add) returns the sum modulo 2^32. It raises res_clamp on signed overflow as defined in R1.
- R9: q_flag goes high one cycle after an accepted operation with res_clamp high. It then stays high whatever the later operations do.
- R10: q_flag is 0 during and after reset. A q_clr pulse lowers it on the next cycle unless an accepted clamping operation occurs in the same cycle, in which case the flag stays high.
- R11: out_valid equals in_valid and in_ready equals out_ready. A clamping operation that is not accepted (in_valid low or out_ready low) leaves q_flag unchanged.
- R12: Opcodes 10 to 15 return 0 and never raise res_clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation can be accepted |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand / value to clip |
| opnd_b | input | 32 | Second operand |
| sat_pos | input | 5 | Clip bit position |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| res | output | 32 | Result |
| res_clamp | output | 1 | This operation clamped |
| q_clr | input | 1 | Clear the sticky flag |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
On every cycle, the assertions check the flag's life cycle: it rises after an accepted clamp, holds until cleared, obeys a clear, and stays low when nothing accepted clamps. They also check that the saturated values of signed add and of unsigned add and subtract are the extremes, and that undefined opcodes stay silent. Only the bench scenarios can show the exact arithmetic boundaries. These include the edge values 0x40000000 and 0xC0000000 for doubling, clip positions 0 and 31, and lanes where only one half clamps. The bench scenarios also cover the interplay of stall, clear and clamp in the same cycle.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  typedef enum logic [3:0] {
    OP_WADD  = 4'd0,
    OP_SADD  = 4'd1,
    OP_SSUB  = 4'd2,
    OP_SDBL  = 4'd3,
    OP_UADD  = 4'd4,
    OP_USUB  = 4'd5,
    OP_SSAT  = 4'd6,
    OP_USAT  = 4'd7,
    OP_SSAT2 = 4'd8,
    OP_USAT2 = 4'd9
  } op_e;
endpackage

// File: rtl/sat_alu_arith.sv
module sat_alu_arith
  import sat_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_e          op,
  output logic [W-1:0] res,
  output logic         clamp
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] QPOS = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] QNEG = {2'b11, {(W-2){1'b0}}};

  logic [W:0]   sum, dif;
  logic         ovf_add, ovf_sub;
  logic [W-1:0] sext;

  always_comb begin
    sum     = {1'b0, a} + {1'b0, b};
    dif     = {1'b0, a} - {1'b0, b};
    ovf_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    ovf_sub = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
    sext    = a[W-1] ? SMIN : SMAX;
    res     = '0;
    clamp   = 1'b0;
    case (op)
      OP_WADD: begin
        res   = sum[W-1:0];
        clamp = ovf_add;
      end
      OP_SADD: begin
        res   = ovf_add ? sext : sum[W-1:0];
        clamp = ovf_add;
      end
      OP_SSUB: begin
        res   = ovf_sub ? sext : dif[W-1:0];
        clamp = ovf_sub;
      end
      OP_SDBL: begin
        if ($signed(a) >= $signed(QPOS)) begin
          res   = SMAX;
          clamp = 1'b1;
        end else if ($signed(a) <= $signed(QNEG)) begin
          res   = SMIN;
          clamp = 1'b1;
        end else begin
          res = {a[W-2:0], 1'b0};
        end
      end
      OP_UADD: begin
        res   = sum[W] ? '1 : sum[W-1:0];
        clamp = sum[W];
      end
      OP_USUB: begin
        res   = dif[W] ? '0 : dif[W-1:0];
        clamp = dif[W];
      end
      default: begin
        res   = '0;
        clamp = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sat_alu_clip.sv
module sat_alu_clip #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [PW-1:0] pos,
  input  logic          is_signed,
  output logic [W-1:0]  res,
  output logic          clamp
);
  logic [W-1:0]        lim;
  logic signed [W-1:0] top;

  always_comb begin
    lim   = (W'(1) << pos) - W'(1);
    top   = $signed(val) >>> pos;
    res   = val;
    clamp = 1'b0;
    if (is_signed) begin
      if (!top[W-1] && (top != '0)) begin
        res   = lim;
        clamp = 1'b1;
      end else if (top[W-1] && (top != '1)) begin
        res   = ~lim;
        clamp = 1'b1;
      end
    end else begin
      if (val[W-1]) begin
        res   = '0;
        clamp = 1'b1;
      end else if (val > lim) begin
        res   = lim;
        clamp = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_alu_sticky.sv
module sat_alu_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3:0]           op_code,
  input  logic [W-1:0]         opnd_a,
  input  logic [W-1:0]         opnd_b,
  input  logic [$clog2(W)-1:0] sat_pos,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         res,
  output logic                 res_clamp,
  input  logic                 q_clr,
  output logic                 q_flag
);
  localparam int LANES = 2;
  localparam int HW    = W / LANES;
  localparam int PW    = $clog2(W);
  localparam int LPW   = $clog2(HW);

  op_e opc;
  assign opc = op_e'(op_code);

  // word-wide add / subtract / doubling
  logic [W-1:0] ar_res;
  logic         ar_clamp;
  sat_alu_arith #(.W(W)) u_arith (
    .a(opnd_a), .b(opnd_b), .op(opc), .res(ar_res), .clamp(ar_clamp)
  );

  // whole-word clip
  logic [W-1:0] wc_res;
  logic         wc_clamp;
  sat_alu_clip #(.W(W), .PW(PW)) u_wclip (
    .val(opnd_a), .pos(sat_pos), .is_signed(opc == OP_SSAT),
    .res(wc_res), .clamp(wc_clamp)
  );

  // per-lane clip; positions past the lane top behave like the top
  logic [LPW-1:0]   lane_pos;
  logic [W-1:0]     lane_res;
  logic [LANES-1:0] lane_clamp;
  assign lane_pos = (sat_pos > PW'(HW-1)) ? LPW'(HW-1) : sat_pos[LPW-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sat_alu_clip #(.W(HW), .PW(LPW)) u_lclip (
      .val(opnd_a[g*HW +: HW]), .pos(lane_pos), .is_signed(opc == OP_SSAT2),
      .res(lane_res[g*HW +: HW]), .clamp(lane_clamp[g])
    );
  end

  always_comb begin
    case (opc)
      OP_SSAT, OP_USAT: begin
        res       = wc_res;
        res_clamp = wc_clamp;
      end
      OP_SSAT2, OP_USAT2: begin
        res       = lane_res;
        res_clamp = |lane_clamp;
      end
      default: begin
        res       = ar_res;
        res_clamp = ar_clamp;
      end
    endcase
  end

  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  sat_alu_sticky u_q (
    .clk(clk), .rst_n(rst_n),
    .set_i(in_valid && out_ready && res_clamp),
    .clr_i(q_clr), .q_o(q_flag)
  );
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_ready,
  input logic [3:0]   op_code,
  input logic [W-1:0] res,
  input logic         res_clamp,
  input logic         q_clr,
  input logic         q_flag
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic take;
  assign take = in_valid && out_ready && res_clamp;

  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> q_flag);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_flag && !q_clr |=> q_flag);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_clr && !take |=> !q_flag);
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !q_flag && !take |=> !q_flag);
  p_sadd_lim_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd1) && res_clamp |-> (res == SMAX) || (res == SMIN));
  p_uadd_lim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd4) && res_clamp |-> res == '1);
  p_usub_lim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd5) && res_clamp |-> res == '0);
  p_undef_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 4'd9) |-> !res_clamp && (res == '0));
endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
  .op_code(op_code), .res(res), .res_clamp(res_clamp),
  .q_clr(q_clr), .q_flag(q_flag)
);

// File: tb/sat_alu_tb_top.sv
module sat_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;
  localparam int NV         = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0, q_clr = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]  sat_pos = '0;
  logic        in_ready, out_valid, res_clamp, q_flag;
  logic [31:0] res;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_pos(sat_pos),
    .out_valid(out_valid), .out_ready(out_ready), .res(res),
    .res_clamp(res_clamp), .q_clr(q_clr), .q_flag(q_flag)
  );

  // {req, op, a, b, pos, expected result, expected clamp}
  localparam logic [109:0] VEC [NV] = '{
    {4'd1, 4'd1, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h7FFFFFFF, 1'b1}, // R1
    {4'd1, 4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1}, // R1
    {4'd1, 4'd1, 32'h00000005, 32'h00000003, 5'd0, 32'h00000008, 1'b0}, // R1
    {4'd2, 4'd2, 32'h80000000, 32'h00000001, 5'd0, 32'h80000000, 1'b1}, // R2
    {4'd2, 4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1}, // R2
    {4'd2, 4'd2, 32'h0000000A, 32'h00000003, 5'd0, 32'h00000007, 1'b0}, // R2
    {4'd3, 4'd3, 32'h40000000, 32'h0,        5'd0, 32'h7FFFFFFF, 1'b1}, // R3
    {4'd3, 4'd3, 32'hC0000000, 32'h0,        5'd0, 32'h80000000, 1'b1}, // R3
    {4'd3, 4'd3, 32'h3FFFFFFF, 32'h0,        5'd0, 32'h7FFFFFFE, 1'b0}, // R3
    {4'd3, 4'd3, 32'hC0000001, 32'h0,        5'd0, 32'h80000002, 1'b0}, // R3
    {4'd4, 4'd4, 32'hFFFFFFFF, 32'h00000002, 5'd0, 32'hFFFFFFFF, 1'b1}, // R4
    {4'd4, 4'd4, 32'h00000001, 32'h00000002, 5'd0, 32'h00000003, 1'b0}, // R4
    {4'd4, 4'd5, 32'h00000001, 32'h00000002, 5'd0, 32'h00000000, 1'b1}, // R4
    {4'd4, 4'd5, 32'h00000005, 32'h00000005, 5'd0, 32'h00000000, 1'b0}, // R4
    {4'd5, 4'd6, 32'h00000100, 32'h0,        5'd7, 32'h0000007F, 1'b1}, // R5
    {4'd5, 4'd6, 32'hFFFFFF00, 32'h0,        5'd7, 32'hFFFFFF80, 1'b1}, // R5
    {4'd5, 4'd6, 32'hFFFFFF80, 32'h0,        5'd7, 32'hFFFFFF80, 1'b0}, // R5
    {4'd5, 4'd6, 32'h0000007F, 32'h0,        5'd7, 32'h0000007F, 1'b0}, // R5
    {4'd5, 4'd6, 32'h00000001, 32'h0,        5'd0, 32'h00000000, 1'b1}, // R5
    {4'd5, 4'd6, 32'h80000000, 32'h0,        5'd31, 32'h80000000, 1'b0}, // R5
    {4'd6, 4'd7, 32'hFFFFFFFF, 32'h0,        5'd8, 32'h00000000, 1'b1}, // R6
    {4'd6, 4'd7, 32'h00000100, 32'h0,        5'd8, 32'h000000FF, 1'b1}, // R6
    {4'd6, 4'd7, 32'h000000FF, 32'h0,        5'd8, 32'h000000FF, 1'b0}, // R6
    {4'd7, 4'd8, 32'h7FFF0100, 32'h0,        5'd7, 32'h007F007F, 1'b1}, // R7
    {4'd7, 4'd8, 32'h00058000, 32'h0,        5'd7, 32'h0005FF80, 1'b1}, // R7
    {4'd7, 4'd8, 32'h0003FFFE, 32'h0,        5'd7, 32'h0003FFFE, 1'b0}, // R7
    {4'd7, 4'd9, 32'h00108000, 32'h0,        5'd8, 32'h00100000, 1'b1}, // R7
    {4'd7, 4'd9, 32'h00200030, 32'h0,        5'd8, 32'h00200030, 1'b0}, // R7
    {4'd8, 4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h80000000, 1'b1}, // R8
    {4'd8, 4'd0, 32'hFFFFFFFF, 32'h00000001, 5'd0, 32'h00000000, 1'b0}, // R8
    {4'd12, 4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 32'h0,      1'b0}  // R12
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] pos);
    op_code = op; opnd_a = a; opnd_b = b; sat_pos = pos;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 flag in reset", 32'(q_flag), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 flag after reset", 32'(q_flag), 32'd0);

    // table walk
    in_valid = 1'b1; out_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][105:102], VEC[i][101:70], VEC[i][69:38], VEC[i][37:33]);
      #1;
      chk($sformatf("R%0d vec %0d result", VEC[i][109:106], i), res, VEC[i][32:1]);
      chk($sformatf("R%0d vec %0d clamp", VEC[i][109:106], i), 32'(res_clamp), 32'(VEC[i][0]));
    end
    @(negedge clk);
    chk("R9 flag after clamps", 32'(q_flag), 32'd1);

    // R9: a non-clamping operation leaves the flag set
    drive(4'd1, 32'd1, 32'd1, 5'd0);
    @(negedge clk);
    chk("R9 flag sticky", 32'(q_flag), 32'd1);

    // R10: clear with nothing offered
    in_valid = 1'b0; q_clr = 1'b1;
    @(negedge clk);
    q_clr = 1'b0;
    chk("R10 clear", 32'(q_flag), 32'd0);

    // R11: stalled clamping operation
    in_valid = 1'b1; out_ready = 1'b0;
    drive(4'd4, 32'hFFFFFFFF, 32'd2, 5'd0);
    #1;
    chk("R11 in_ready follows", 32'(in_ready), 32'd0);
    chk("R11 out_valid follows", 32'(out_valid), 32'd1);
    chk("R11 result during stall", res, 32'hFFFFFFFF);
    @(negedge clk);
    chk("R11 stall no flag", 32'(q_flag), 32'd0);

    // R11: not valid
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk("R11 invalid no flag", 32'(q_flag), 32'd0);

    // R7: only the upper lane clamps
    in_valid = 1'b1;
    drive(4'd9, 32'h01000010, 32'd0, 5'd8);
    #1;
    chk("R7 upper lane result", res, 32'h00FF0010);
    @(negedge clk);
    chk("R7 upper lane sets flag", 32'(q_flag), 32'd1);

    // R10: clear coincident with clamp, then clear alone
    q_clr = 1'b1;
    drive(4'd2, 32'h80000000, 32'd1, 5'd0);
    @(negedge clk);
    chk("R10 clamp beats clear", 32'(q_flag), 32'd1);
    drive(4'd2, 32'd9, 32'd1, 5'd0);
    @(negedge clk);
    q_clr = 1'b0;
    chk("R10 clear alone", 32'(q_flag), 32'd0);

    // R10: reset mid-run
    drive(4'd3, 32'h7FFFFFFF, 32'd0, 5'd0);
    @(negedge clk);
    chk("R3 flag from doubling", 32'(q_flag), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears flag", 32'(q_flag), 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule